// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Controller

This block turns interrupt requests from a device function into memory-write messages. It keeps a table of up to 32 vector entries and a pending-bit array. Each entry holds a 64-bit target address, a 32-bit payload and a per-vector mask. Software programs the table through a 32-bit register port. The port works in words and covers a 4 KiB window: the table fills the lower half and the pending bits sit at byte offset 0x800. Two control inputs carry the function-level enable and mask-all settings.

The device logic raises a request by giving a vector index. If the vector is usable and not masked, the controller puts the entry's address and payload on an output message channel. That channel uses a valid/ready handshake. If the vector is masked, the controller records the request in the pending array. The pending request is replayed automatically once the vector becomes unmasked. This can happen through a table write or through a change of the function-level mask. In the second case the controller walks the vectors one per clock.

A per-vector in-use count sets which vectors may send at all. Requests on unused vectors are dropped.

Top module: `msgvec_ctrl_top`

## Requirements
- R1: A synchronous reset leaves every table word at zero except the mask, which is set for every vector. It also clears the pending array and all in-use counts, and it treats the function as masked. Afterwards no message is offered and both ready outputs are high.
- R2: The register port addresses 32-bit words: word address w is byte offset 4*w. Entry n starts at byte offset 16*n. Its words are, in order: address low (+0), address high (+4), payload (+8) and vector control (+12). Only bit 0 of vector control is stored; it is the mask, and the other bits read as zero.
- R3: The pending array reads from byte offset 0x800, with vector n at bit n of that word. Every other word in the upper half reads zero. A write whose entry number (byte offset / 16) is at or above NUM_VEC is dropped, so the pending array cannot be written.
- R4: A vector is effectively masked when ctl_enable is low, when ctl_mask_all is high, or when its own mask bit is set. Lowering ctl_enable starts no vector walk and sends nothing.
- R5: An accepted request on a masked, in-use vector sets that vector's pending bit and sends nothing.
- R6: An accepted request on an unmasked, in-use vector offers {address high, address low} and the payload on the cycle after acceptance. The message holds stable until msg_ready is seen.
- R7: A request is dropped when its index is at or above NUM_VEC, or when the vector's in-use count is zero.
- R8: Suppose a write to a vector-control word clears the mask, the function mask is clear, and the pending bit is set. Then that pending bit is cleared and the entry's message is offered on the next cycle.
- R9: The effective function mask can change from set to clear while ctl_enable is high. The controller then checks the vectors one per clock in ascending index order. For each vector that was masked before and is unmasked now and has a pending bit, it clears the bit and sends one message. Vectors whose own mask is set stay pending.
- R10: use_inc and use_dec step the selected vector's count up or down. A decrement that reaches zero clears that vector's pending bit. A decrement on a zero count is ignored.
- R11: reg_wr_ready and irq_ready are low while a message waits for msg_ready and while a vector walk runs. irq_ready is also low in any cycle with reg_wr high, so a register write wins over a request.
- R12: A request is judged against the in-use count from before any use update in the same cycle. If a decrement to zero meets a masked request on the same vector, the pending bit ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Word address of the write within the 4 KiB window |
| reg_wdata | input | 32 | Write data |
| reg_wr_ready | output | 1 | Write accepted on this edge when high |
| rd_addr | input | 10 | Word address of the combinational read |
| rd_data | output | 32 | Read data |
| ctl_enable | input | 1 | Function-level enable |
| ctl_mask_all | input | 1 | Function-level mask-all |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | VID_W | Requested vector index |
| irq_ready | output | 1 | Request accepted on this edge when high |
| use_inc | input | 1 | Increment the in-use count of use_vec |
| use_dec | input | 1 | Decrement the in-use count of use_vec |
| use_vec | input | VID_W | Vector whose count is updated |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The use-count port and the request port can act on the same vector in the same clock. This matters most when a decrement that empties the count meets a masked request. The bench drives use_dec and irq_valid for one vector in one cycle, then reads the pending word to confirm the bit ended clear. It does the same with an increment from zero and a request, to confirm the request was dropped. A later lone request on that vector sets the pending bit, which proves the increment itself took effect.

// File: rtl/msgvec_pkg.sv
package msgvec_pkg;

    localparam int WORD_W    = 32;
    localparam int MADDR_W   = 64;
    localparam int WADDR_W   = 10;   // word address bits for a 4 KiB window
    localparam int ENT_NUM_W = 8;    // entry number bits inside the window

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_DATA    = 2'd2,
        SEL_CTRL    = 2'd3
    } word_sel_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_SCAN = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [MADDR_W-1:0] addr;
        logic [WORD_W-1:0]  data;
    } msg_t;

    function automatic logic eff_masked(input logic fmask, input logic vmask);
        return fmask | vmask;
    endfunction

    function automatic logic [ENT_NUM_W-1:0] entry_of(input logic [WADDR_W-1:0] w);
        return w[WADDR_W-1:2];
    endfunction

    function automatic word_sel_e sel_of(input logic [WADDR_W-1:0] w);
        return word_sel_e'(w[1:0]);
    endfunction

endpackage

// File: rtl/msgvec_store.sv
module msgvec_store
    import msgvec_pkg::*;
#(
    parameter int NUM_VEC = 32,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  word_sel_e          wr_sel,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    input  word_sel_e          rd_sel,
    output logic [WORD_W-1:0]  rd_word,
    input  logic [IDX_W-1:0]   tx_idx,
    output msg_t               tx_msg,
    output logic [NUM_VEC-1:0] mask_vec
);

    logic [WORD_W-1:0] lo_w  [NUM_VEC];
    logic [WORD_W-1:0] hi_w  [NUM_VEC];
    logic [WORD_W-1:0] dat_w [NUM_VEC];

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
        logic [WORD_W-1:0] lo_q, hi_q, dat_q;
        logic              msk_q;
        logic              sel_me;

        assign sel_me = wr_en && (wr_idx == IDX_W'(v));

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q  <= '0;
                hi_q  <= '0;
                dat_q <= '0;
                msk_q <= 1'b1;
            end else if (sel_me) begin
                unique case (wr_sel)
                    SEL_ADDR_LO: lo_q  <= wr_data;
                    SEL_ADDR_HI: hi_q  <= wr_data;
                    SEL_DATA:    dat_q <= wr_data;
                    SEL_CTRL:    msk_q <= wr_data[0];
                endcase
            end
        end

        assign lo_w[v]     = lo_q;
        assign hi_w[v]     = hi_q;
        assign dat_w[v]    = dat_q;
        assign mask_vec[v] = msk_q;
    end

    always_comb begin
        unique case (rd_sel)
            SEL_ADDR_LO: rd_word = lo_w[rd_idx];
            SEL_ADDR_HI: rd_word = hi_w[rd_idx];
            SEL_DATA:    rd_word = dat_w[rd_idx];
            SEL_CTRL:    rd_word = {{(WORD_W-1){1'b0}}, mask_vec[rd_idx]};
        endcase
    end

    assign tx_msg.addr = {hi_w[tx_idx], lo_w[tx_idx]};
    assign tx_msg.data = dat_w[tx_idx];

    AST_RESET_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&mask_vec)); // R1

endmodule

// File: rtl/msgvec_usage.sv
module msgvec_usage
    import msgvec_pkg::*;
#(
    parameter int NUM_VEC = 32,
    parameter int CNT_W   = 4,
    parameter int IDX_W   = 5,
    parameter int VID_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               use_inc,
    input  logic               use_dec,
    input  logic [VID_W-1:0]   use_vec,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_VEC-1:0] pend_vec,
    output logic [NUM_VEC-1:0] in_use
);

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        logic [CNT_W-1:0] cnt_q;
        logic             pend_q;
        logic             hit, inc_v, dec_v, drop_v;

        assign hit    = (use_vec == VID_W'(v));
        assign inc_v  = use_inc && !use_dec && hit && (cnt_q != '1);
        assign dec_v  = use_dec && !use_inc && hit && (cnt_q != '0);
        assign drop_v = dec_v && (cnt_q == CNT_W'(1));

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (inc_v) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (dec_v) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end

        // clearing wins over a same-cycle capture
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= 1'b0;
            end else if ((clr_en && clr_idx == IDX_W'(v)) || drop_v) begin
                pend_q <= 1'b0;
            end else if (set_en && set_idx == IDX_W'(v)) begin
                pend_q <= 1'b1;
            end
        end

        assign pend_vec[v] = pend_q;
        assign in_use[v]   = (cnt_q != '0);
    end

    AST_PEND_NEEDS_USE: assert property (@(posedge clk) disable iff (rst)
        (pend_vec & ~in_use) == '0); // R10

endmodule

// File: rtl/msgvec_seq.sv
module msgvec_seq
    import msgvec_pkg::*;
#(
    parameter int NUM_VEC = 32,
    parameter int IDX_W   = 5,
    parameter int VID_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_enable,
    input  logic               ctl_mask_all,
    input  logic               reg_wr,
    input  logic [WADDR_W-1:0] reg_addr,
    input  logic               wr_mask_bit,
    output logic               reg_wr_ready,
    output logic               st_wr_en,
    output logic [IDX_W-1:0]   st_wr_idx,
    output word_sel_e          st_wr_sel,
    input  logic               irq_valid,
    input  logic [VID_W-1:0]   irq_vec,
    output logic               irq_ready,
    input  logic [NUM_VEC-1:0] mask_vec,
    input  logic [NUM_VEC-1:0] pend_vec,
    input  logic [NUM_VEC-1:0] in_use,
    output logic               pend_set_en,
    output logic [IDX_W-1:0]   pend_set_idx,
    output logic               pend_clr_en,
    output logic [IDX_W-1:0]   pend_clr_idx,
    output logic [IDX_W-1:0]   tx_idx,
    input  msg_t               tx_msg,
    output logic               msg_valid,
    input  logic               msg_ready,
    output msg_t               msg_out
);

    localparam logic [ENT_NUM_W-1:0] NV_ENT  = ENT_NUM_W'(NUM_VEC);
    localparam logic [VID_W-1:0]     NV_VID  = VID_W'(NUM_VEC);
    localparam logic [IDX_W-1:0]     LAST_IX = IDX_W'(NUM_VEC - 1);

    seq_state_e       st_q;
    logic             fm_q, old_fm_q;
    logic [IDX_W-1:0] sidx_q;
    logic             msg_valid_q;
    msg_t             msg_q;

    logic                 fm_next, idle;
    logic [ENT_NUM_W-1:0] w_ent;
    word_sel_e            w_sel;
    logic [IDX_W-1:0]     w_idx, i_idx;
    logic                 wr_fire, wr_hit, wr_emit;
    logic                 irq_fire, irq_ok, irq_masked, irq_emit, irq_park;
    logic                 scan_go, scan_emit, emit;

    assign fm_next = !ctl_enable || ctl_mask_all;
    assign idle    = (st_q == SQ_IDLE) && !msg_valid_q;

    // register write path
    assign w_ent   = entry_of(reg_addr);
    assign w_sel   = sel_of(reg_addr);
    assign w_idx   = w_ent[IDX_W-1:0];
    assign wr_fire = reg_wr && idle;
    assign wr_hit  = wr_fire && (w_ent < NV_ENT);
    assign wr_emit = wr_hit && (w_sel == SEL_CTRL) && mask_vec[w_idx]
                     && !wr_mask_bit && !fm_q && pend_vec[w_idx];

    // request path
    assign i_idx      = irq_vec[IDX_W-1:0];
    assign irq_fire   = irq_valid && idle && !reg_wr;
    assign irq_ok     = irq_fire && (irq_vec < NV_VID) && in_use[i_idx];
    assign irq_masked = eff_masked(fm_q, mask_vec[i_idx]);
    assign irq_emit   = irq_ok && !irq_masked;
    assign irq_park   = irq_ok && irq_masked;

    // walk after a function mask change
    assign scan_go   = (st_q == SQ_SCAN) && !msg_valid_q;
    assign scan_emit = scan_go
                       && eff_masked(old_fm_q, mask_vec[sidx_q])
                       && !eff_masked(fm_q, mask_vec[sidx_q])
                       && pend_vec[sidx_q];

    assign emit   = wr_emit | irq_emit | scan_emit;
    assign tx_idx = scan_go ? sidx_q : (wr_fire ? w_idx : i_idx);

    assign pend_set_en  = irq_park;
    assign pend_set_idx = i_idx;
    assign pend_clr_en  = wr_emit | scan_emit;
    assign pend_clr_idx = scan_go ? sidx_q : w_idx;

    assign st_wr_en  = wr_hit;
    assign st_wr_idx = w_idx;
    assign st_wr_sel = w_sel;

    assign reg_wr_ready = idle;
    assign irq_ready    = idle && !reg_wr;
    assign msg_valid    = msg_valid_q;
    assign msg_out      = msg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid_q <= 1'b0;
            msg_q       <= '0;
        end else if (emit) begin
            msg_valid_q <= 1'b1;
            msg_q       <= tx_msg;
        end else if (msg_valid_q && msg_ready) begin
            msg_valid_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SQ_IDLE;
            fm_q     <= 1'b1;
            old_fm_q <= 1'b1;
            sidx_q   <= '0;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    if (fm_next != fm_q) begin
                        fm_q <= fm_next;
                        if (ctl_enable) begin
                            st_q     <= SQ_SCAN;
                            old_fm_q <= fm_q;
                            sidx_q   <= '0;
                        end
                    end
                end
                SQ_SCAN: begin
                    if (scan_go) begin
                        sidx_q <= sidx_q + IDX_W'(1);
                        if (sidx_q == LAST_IX) begin
                            st_q <= SQ_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    AST_MSG_HELD: assert property (@(posedge clk) disable iff (rst)
        msg_valid_q && !msg_ready |=> msg_valid_q && $stable(msg_q)); // R6

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_emit, irq_emit, scan_emit})); // R11

    AST_SCAN_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        scan_go |=> (sidx_q != $past(sidx_q)) || (st_q == SQ_IDLE)); // R9

    AST_REPLAY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        scan_emit |=> msg_valid_q && !pend_vec[$past(sidx_q)]); // R9

    AST_UNMASK_WRITE_SENDS: assert property (@(posedge clk) disable iff (rst)
        wr_emit |=> msg_valid_q && !pend_vec[$past(w_idx)]); // R8

endmodule

// File: rtl/msgvec_ctrl_top.sv
module msgvec_ctrl_top
    import msgvec_pkg::*;
#(
    parameter int  NUM_VEC = 32,
    parameter int  CNT_W   = 4,
    localparam int VID_W   = $clog2(NUM_VEC) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [WADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic               reg_wr_ready,
    input  logic [WADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    input  logic               ctl_enable,
    input  logic               ctl_mask_all,
    input  logic               irq_valid,
    input  logic [VID_W-1:0]   irq_vec,
    output logic               irq_ready,
    input  logic               use_inc,
    input  logic               use_dec,
    input  logic [VID_W-1:0]   use_vec,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [MADDR_W-1:0] msg_addr,
    output logic [WORD_W-1:0]  msg_data
);

    localparam int IDX_W = $clog2(NUM_VEC);
    localparam logic [ENT_NUM_W-1:0] NV_ENT = ENT_NUM_W'(NUM_VEC);

    logic               st_wr_en;
    logic [IDX_W-1:0]   st_wr_idx;
    word_sel_e          st_wr_sel;
    logic [IDX_W-1:0]   tx_idx;
    msg_t               tx_msg, msg_out;
    logic [NUM_VEC-1:0] mask_vec, pend_vec, in_use;
    logic               pend_set_en, pend_clr_en;
    logic [IDX_W-1:0]   pend_set_idx, pend_clr_idx;
    logic [WORD_W-1:0]  rd_word;
    logic [ENT_NUM_W-1:0] r_ent;

    assign r_ent = entry_of(rd_addr);

    msgvec_store #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (st_wr_en),
        .wr_idx   (st_wr_idx),
        .wr_sel   (st_wr_sel),
        .wr_data  (reg_wdata),
        .rd_idx   (r_ent[IDX_W-1:0]),
        .rd_sel   (sel_of(rd_addr)),
        .rd_word  (rd_word),
        .tx_idx   (tx_idx),
        .tx_msg   (tx_msg),
        .mask_vec (mask_vec)
    );

    msgvec_usage #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W), .IDX_W(IDX_W), .VID_W(VID_W)) u_usage (
        .clk      (clk),
        .rst      (rst),
        .use_inc  (use_inc),
        .use_dec  (use_dec),
        .use_vec  (use_vec),
        .set_en   (pend_set_en),
        .set_idx  (pend_set_idx),
        .clr_en   (pend_clr_en),
        .clr_idx  (pend_clr_idx),
        .pend_vec (pend_vec),
        .in_use   (in_use)
    );

    msgvec_seq #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .VID_W(VID_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .ctl_enable   (ctl_enable),
        .ctl_mask_all (ctl_mask_all),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .wr_mask_bit  (reg_wdata[0]),
        .reg_wr_ready (reg_wr_ready),
        .st_wr_en     (st_wr_en),
        .st_wr_idx    (st_wr_idx),
        .st_wr_sel    (st_wr_sel),
        .irq_valid    (irq_valid),
        .irq_vec      (irq_vec),
        .irq_ready    (irq_ready),
        .mask_vec     (mask_vec),
        .pend_vec     (pend_vec),
        .in_use       (in_use),
        .pend_set_en  (pend_set_en),
        .pend_set_idx (pend_set_idx),
        .pend_clr_en  (pend_clr_en),
        .pend_clr_idx (pend_clr_idx),
        .tx_idx       (tx_idx),
        .tx_msg       (tx_msg),
        .msg_valid    (msg_valid),
        .msg_ready    (msg_ready),
        .msg_out      (msg_out)
    );

    // read path: table in the lower half, pending word at the start of the upper half
    always_comb begin
        if (rd_addr[WADDR_W-1]) begin
            rd_data = (rd_addr[WADDR_W-2:0] == '0) ? WORD_W'(pend_vec) : '0;
        end else if (r_ent < NV_ENT) begin
            rd_data = rd_word;
        end else begin
            rd_data = '0;
        end
    end

    assign msg_addr = msg_out.addr;
    assign msg_data = msg_out.data;

    AST_NO_WRITE_WHILE_OFFERING: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !reg_wr_ready && !irq_ready); // R11

endmodule

// File: tb/msgvec_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module msgvec_ctrl_top_tb_top;

    localparam int NV    = 32;
    localparam int VID_W = $clog2(NV) + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [9:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic              reg_wr_ready;
    logic [9:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic              ctl_enable = 1'b0;
    logic              ctl_mask_all = 1'b0;
    logic              irq_valid = 1'b0;
    logic [VID_W-1:0]  irq_vec = '0;
    logic              irq_ready;
    logic              use_inc = 1'b0;
    logic              use_dec = 1'b0;
    logic [VID_W-1:0]  use_vec = '0;
    logic              msg_valid;
    logic              msg_ready = 1'b0;
    logic [63:0]       msg_addr;
    logic [31:0]       msg_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    msgvec_ctrl_top #(.NUM_VEC(NV)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr_ready(reg_wr_ready), .rd_addr(rd_addr),
        .rd_data(rd_data), .ctl_enable(ctl_enable), .ctl_mask_all(ctl_mask_all),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ready(irq_ready),
        .use_inc(use_inc), .use_dec(use_dec), .use_vec(use_vec),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data)
    );

    // write word address, write data, read word address, expected read
    localparam int NT = 9;
    localparam logic [83:0] TBL [NT] = '{
        {10'h000, 32'hAAAA0000, 10'h000, 32'hAAAA0000},  // R2 entry 0 address low
        {10'h005, 32'h12345678, 10'h005, 32'h12345678},  // R2 entry 1 address high
        {10'h00A, 32'hDEADBEEF, 10'h00A, 32'hDEADBEEF},  // R2 entry 2 payload
        {10'h00F, 32'hFFFFFFFE, 10'h00F, 32'h00000000},  // R2 only mask bit kept
        {10'h00F, 32'h00000003, 10'h00F, 32'h00000001},  // R2 mask set again
        {10'h07E, 32'h0BADF00D, 10'h07E, 32'h0BADF00D},  // R2 last entry payload
        {10'h00D, 32'h00000077, 10'h00C, 32'h00000000},  // R2 neighbour word untouched
        {10'h080, 32'h00000055, 10'h080, 32'h00000000},  // R3 entry past NUM_VEC dropped
        {10'h200, 32'hFFFFFFFF, 10'h200, 32'h00000000}   // R3 pending word read-only
    };

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        for (int i = 0; i < 200 && !reg_wr_ready; i++) tick();
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [9:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, 96'(rd_data), 96'(exp));
    endtask

    task automatic req(input int v);
        irq_vec   = VID_W'(v);
        irq_valid = 1'b1;
        for (int i = 0; i < 200 && !irq_ready; i++) tick();
        tick();
        irq_valid = 1'b0;
    endtask

    task automatic use_op(input int v, input bit inc, input bit dec);
        use_vec = VID_W'(v);
        use_inc = inc;
        use_dec = dec;
        tick();
        use_inc = 1'b0;
        use_dec = 1'b0;
    endtask

    task automatic take_msg(input string tag, input logic [63:0] ea, input logic [31:0] ed);
        for (int i = 0; i < 300 && !msg_valid; i++) tick();
        chk({tag, " valid"}, 96'(msg_valid), 96'(1));
        chk({tag, " addr"}, 96'(msg_addr), 96'(ea));
        chk({tag, " data"}, 96'(msg_data), 96'(ed));
        msg_ready = 1'b1;
        tick();
        msg_ready = 1'b0;
    endtask

    task automatic prog(input int v, input logic [63:0] a, input logic [31:0] d, input bit m);
        wr(10'(v * 4 + 0), a[31:0]);
        wr(10'(v * 4 + 1), a[63:32]);
        wr(10'(v * 4 + 2), d);
        wr(10'(v * 4 + 3), {31'b0, m});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 msg_valid", 96'(msg_valid), 96'(0));
        chk("R1 ready", 96'({reg_wr_ready, irq_ready}), 96'(2'b11));
        rdchk("R1 ctrl word", 10'h017, 32'h1);
        rdchk("R1 addr low", 10'h014, 32'h0);
        rdchk("R1 pending", 10'h200, 32'h0);

        // R2 R3 table walk
        for (int t = 0; t < NT; t++) begin
            wr(TBL[t][83:74], TBL[t][73:42]);
            rdchk($sformatf("R2/R3 vector %0d", t), TBL[t][41:32], TBL[t][31:0]);
        end

        do_reset();
        rdchk("R1 after reuse ctrl", 10'h00F, 32'h1);
        rdchk("R1 after reuse data", 10'h00A, 32'h0);

        // R11 walk blocks requests
        ctl_enable = 1'b1;
        tick();
        chk("R11 busy during walk", 96'({reg_wr_ready, irq_ready}), 96'(0));
        repeat (NV + 8) tick();

        // R6 unmasked request, held without ready
        prog(2, 64'h0000_0001_1000_0020, 32'hCAFE0002, 1'b0);
        use_op(2, 1, 0);
        req(2);
        tick();
        tick();
        chk("R6 held valid", 96'(msg_valid), 96'(1));
        chk("R11 write stalled while offering", 96'(reg_wr_ready), 96'(0));
        take_msg("R6 message", 64'h0000_0001_1000_0020, 32'hCAFE0002);
        chk("R6 valid dropped", 96'(msg_valid), 96'(0));

        // R7 unused and out-of-range vectors
        prog(3, 64'h33, 32'h3333, 1'b0);
        req(3);
        chk("R7 unused vector", 96'(msg_valid), 96'(0));
        req(NV + 1);
        chk("R7 out of range", 96'(msg_valid), 96'(0));
        rdchk("R7 no pending", 10'h200, 32'h0);

        // R5 masked request parks
        prog(4, 64'h0000_0000_4000_0040, 32'h00440044, 1'b1);
        use_op(4, 1, 0);
        req(4);
        chk("R5 masked sends nothing", 96'(msg_valid), 96'(0));
        rdchk("R5 pending bit 4", 10'h200, 32'h10);

        // R8 unmask by table write replays
        wr(10'h013, 32'h0);
        take_msg("R8 replay", 64'h0000_0000_4000_0040, 32'h00440044);
        rdchk("R8 pending cleared", 10'h200, 32'h0);

        // R9 function mask walk replays in order
        ctl_mask_all = 1'b1;
        tick();
        repeat (NV + 8) tick();
        prog(5, 64'h0000_0005_5000_0050, 32'h55, 1'b0);
        prog(6, 64'h0000_0006_6000_0060, 32'h66, 1'b0);
        prog(7, 64'h0000_0007_7000_0070, 32'h77, 1'b1);
        use_op(5, 1, 0);
        use_op(6, 1, 0);
        use_op(7, 1, 0);
        req(5);
        req(6);
        req(7);
        chk("R4 mask-all blocks", 96'(msg_valid), 96'(0));
        rdchk("R4 parked 5,6,7", 10'h200, 32'hE0);
        ctl_mask_all = 1'b0;
        take_msg("R9 first replay", 64'h0000_0005_5000_0050, 32'h55);
        take_msg("R9 second replay", 64'h0000_0006_6000_0060, 32'h66);
        repeat (NV + 8) tick();
        chk("R9 own-masked not sent", 96'(msg_valid), 96'(0));
        rdchk("R9 vector 7 still pending", 10'h200, 32'h80);

        // R4 enable low: no walk, requests park
        ctl_enable = 1'b0;
        tick();
        chk("R4 no walk on disable", 96'(irq_ready), 96'(1));
        req(2);
        chk("R4 disabled sends nothing", 96'(msg_valid), 96'(0));
        rdchk("R4 parked 2", 10'h200, 32'h84);

        // R10 counts
        use_op(2, 0, 1);
        rdchk("R10 drop to zero clears", 10'h200, 32'h80);
        use_op(2, 0, 1);
        use_op(2, 1, 0);
        req(2);
        rdchk("R10 zero decrement ignored", 10'h200, 32'h84);

        // R12 same-cycle decrement to zero and masked request
        use_op(2, 0, 1);
        use_op(2, 1, 0);
        req(2);
        use_vec   = VID_W'(2);
        use_dec   = 1'b1;
        irq_vec   = VID_W'(2);
        irq_valid = 1'b1;
        tick();
        use_dec   = 1'b0;
        irq_valid = 1'b0;
        rdchk("R12 clear wins", 10'h200, 32'h80);

        // R12 increment from zero with request in the same cycle
        use_vec   = VID_W'(9);
        use_inc   = 1'b1;
        irq_vec   = VID_W'(9);
        irq_valid = 1'b1;
        tick();
        use_inc   = 1'b0;
        irq_valid = 1'b0;
        rdchk("R12 request sees old count", 10'h200, 32'h80);
        req(9);
        rdchk("R12 count took effect", 10'h200, 32'h280);

        // R11 write has priority over request
        reg_addr  = 10'h0FF;
        reg_wdata = 32'h0;
        reg_wr    = 1'b1;
        irq_valid = 1'b1;
        #1;
        chk("R11 irq_ready low with write", 96'(irq_ready), 96'(0));
        reg_wr    = 1'b0;
        irq_valid = 1'b0;

        do_reset();
        rdchk("R1 pending after reset", 10'h200, 32'h0);
        rdchk("R1 entry 2 data after reset", 10'h00A, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule